// File: doc/BRIEF.md
# Pulse Width Capture Timer

This block measures the time between successive valid edges on one of two capture inputs. A 16-bit counter advances on a count clock enable. Each valid edge on the active capture input copies the count into that input's capture register and clears the counter to zero in the same step. The stored value is therefore the edge-to-edge interval, and a one-cycle capture interrupt tells software that a new interval can be read.

The count clock enable comes from one of two sources. The first is an internal prescaler that gives one tick every 1, 2, 4 or 8 system clocks. The second is the rising edges of input 0, used as an external event clock. When input 0 is the clock, only input 1 can capture. Each input passes through its own two-flop synchronizer and edge detector, and the edge type for each input is programmable. When the counter wraps past its top value, it raises a one-cycle overflow pulse.

Top module: `pwc_timer`

## Requirements
- R1: While reset is asserted and directly after it is released, both capture values read 0 and all three interrupt outputs are low.
- R2: At prescale 1, valid edges D cycles apart store D-1 in the capture register. A capture clears the counter, so every later interval in a train reads the same value.
- R3: Each input's 2-bit edge select is decoded as 00 = none, 01 = rising, 10 = falling, 11 = both. An input set to none never captures, and its capture value stays unchanged.
- R4: Prescale code p (0..3) gives one count tick every 2^p system clocks. An edge that arrives between ticks is held and captured on the next tick, so edges D cycles apart (D a multiple of 2^p) store D/2^p - 1.
- R5: With src_ext = 1 the counter advances once per rising edge of input 0, and input 0 never captures, whatever its edge select.
- R6: When a tick finds the counter at 0xFFFF and no capture is due, the counter wraps to 0 and ovf_irq pulses for exactly one cycle. A long interval is captured as its low 16 bits.
- R7: While run_en is 0 the counter is held at 0, no capture or overflow occurs, and both capture values keep their last contents.
- R8: Counting restarts from 0 when run_en is set. At prescale 1, a rising edge driven K cycles after run_en is raised (both driven at clock midpoints) is captured as K+2, which includes the two-flop synchronizer delay.
- R9: A capture interrupt is high for the single cycle in which the new value first appears on that channel's capture output. Between captures the output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Count enable; 0 holds the counter at zero |
| src_ext | input | 1 | 1 selects rising edges of input 0 as the count clock |
| presc_sel | input | 2 | Internal prescale code: 1, 2, 4 or 8 clocks per tick |
| edge_sel0 | input | 2 | Edge select for input 0 |
| edge_sel1 | input | 2 | Edge select for input 1 |
| cap_in0 | input | 1 | Asynchronous input 0 (capture trigger or event clock) |
| cap_in1 | input | 1 | Asynchronous input 1 (capture trigger) |
| cap0_val | output | 16 | Last value captured by input 0 |
| cap1_val | output | 16 | Last value captured by input 1 |
| cap0_irq | output | 1 | One-cycle capture pulse for input 0 |
| cap1_irq | output | 1 | One-cycle capture pulse for input 1 |
| ovf_irq | output | 1 | One-cycle counter wrap pulse |

## Verification
A wrong counter or prescaler state appears at the next capture as a value that is off by a fixed amount, and it does so within one edge interval of the fault. A stuck pending flag or a wrong edge decode appears as a capture pulse on the wrong channel, a missing pulse, or a doubled pulse. The scoreboard catches these the cycle they occur, because every pulse must match a queued expectation. A fault in the wrap logic only appears after 65536 ticks, as a missing or repeated overflow pulse inside a long interval.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  function automatic logic edge_match(edge_mode_e mode, logic rise, logic fall);
    logic m;
    case (mode)
      EDGE_RISE: m = rise;
      EDGE_FALL: m = fall;
      EDGE_ANY:  m = rise | fall;
      default:   m = 1'b0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pwc_edge_det.sv
module pwc_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                din,
  input  pwc_pkg::edge_mode_e mode,
  output logic                rise,
  output logic                hit
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;
  logic                   fall;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    rise = sync_q[SYNC_STAGES-1] & ~prev_q;
    fall = ~sync_q[SYNC_STAGES-1] & prev_q;
    hit  = pwc_pkg::edge_match(mode, rise, fall);
  end
endmodule

// File: rtl/pwc_tick_gen.sv
module pwc_tick_gen #(
  parameter int PRE_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ext_sel,
  input  logic [1:0] presc_sel,
  input  logic       ext_rise,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q, pre_d, limit;
  logic             int_tick;

  always_comb begin
    case (presc_sel)
      2'd0:    limit = PRE_W'(0);
      2'd1:    limit = PRE_W'(1);
      2'd2:    limit = PRE_W'(3);
      default: limit = PRE_W'(7);
    endcase
    int_tick = (pre_q >= limit);
    if (!run || int_tick) pre_d = '0;
    else                  pre_d = pre_q + PRE_W'(1);
    tick = run & (ext_sel ? ext_rise : int_tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/pwc_capture_chan.sv
module pwc_capture_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          allow,
  input  logic          hit,
  input  logic [CW-1:0] cnt,
  output logic          fire,
  output logic [CW-1:0] cap_val,
  output logic          irq
);
  logic          pend_q, pend_d;
  logic [CW-1:0] cap_q, cap_d;
  logic          irq_q, irq_d;

  always_comb begin
    fire   = tick & run & allow & (pend_q | hit);
    pend_d = run & allow & ~tick & (pend_q | hit);
    cap_d  = fire ? cnt : cap_q;
    irq_d  = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cap_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
      if (fire) cap_q <= cap_d;
    end
  end

  assign cap_val = cap_q;
  assign irq     = irq_q;
endmodule

// File: rtl/pwc_timer.sv
module pwc_timer #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          src_ext,
  input  logic [1:0]    presc_sel,
  input  logic [1:0]    edge_sel0,
  input  logic [1:0]    edge_sel1,
  input  logic          cap_in0,
  input  logic          cap_in1,
  output logic [CW-1:0] cap0_val,
  output logic [CW-1:0] cap1_val,
  output logic          cap0_irq,
  output logic          cap1_irq,
  output logic          ovf_irq
);
  import pwc_pkg::*;

  localparam int NCH = 2;
  localparam logic [NCH-1:0] EXT_MASK = NCH'(1);
  localparam logic [CW-1:0]  CNT_TOP  = {CW{1'b1}};

  logic [NCH-1:0]          pin, rise_v, hit_v, allow_v, fire_v, irq_v;
  edge_mode_e              mode_v [NCH];
  logic [NCH-1:0][CW-1:0]  cap_v;
  logic                    tick, ext_rise, any_fire;
  logic [CW-1:0]           cnt_q, cnt_d;
  logic                    ovf_q, ovf_d;

  always_comb begin
    pin       = {cap_in1, cap_in0};
    mode_v[0] = edge_mode_e'(edge_sel0);
    mode_v[1] = edge_mode_e'(edge_sel1);
    allow_v[0] = (mode_v[0] != EDGE_OFF) & ~src_ext;
    allow_v[1] = (mode_v[1] != EDGE_OFF);
    ext_rise   = |(rise_v & EXT_MASK);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk(clk), .rst_n(rst_n), .din(pin[g]), .mode(mode_v[g]),
      .rise(rise_v[g]), .hit(hit_v[g])
    );
    pwc_capture_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n), .run(run_en), .tick(tick),
      .allow(allow_v[g]), .hit(hit_v[g]), .cnt(cnt_q),
      .fire(fire_v[g]), .cap_val(cap_v[g]), .irq(irq_v[g])
    );
  end

  pwc_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run_en), .ext_sel(src_ext),
    .presc_sel(presc_sel), .ext_rise(ext_rise), .tick(tick)
  );

  always_comb begin
    any_fire = |fire_v;
    ovf_d    = tick & ~any_fire & (cnt_q == CNT_TOP);
    if (!run_en || any_fire) cnt_d = '0;
    else if (tick)           cnt_d = cnt_q + CW'(1);
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cap0_val = cap_v[0];
  assign cap1_val = cap_v[1];
  assign cap0_irq = irq_v[0];
  assign cap1_irq = irq_v[1];
  assign ovf_irq  = ovf_q;
endmodule

// File: rtl/pwc_timer_chk.sv
module pwc_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          src_ext,
  input logic [1:0]    edge_sel0,
  input logic [1:0]    edge_sel1,
  input logic [CW-1:0] cap0_val,
  input logic [CW-1:0] cap1_val,
  input logic          cap0_irq,
  input logic          cap1_irq,
  input logic          ovf_irq
);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!cap0_irq && !cap1_irq && !ovf_irq));

  // R3
  off0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel0 == 2'b00) |=> !cap0_irq);

  // R3
  off1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel1 == 2'b00) |=> !cap1_irq);

  // R5
  ext_no_cap0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ext |=> !cap0_irq);

  // R6
  ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq);

  // R6
  ovf_not_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> !(cap0_irq || cap1_irq));

  // R9
  hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap0_irq |-> $stable(cap0_val));

  // R9
  hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap1_irq |-> $stable(cap1_val));
endmodule

bind pwc_timer pwc_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_ext(src_ext),
  .edge_sel0(edge_sel0), .edge_sel1(edge_sel1),
  .cap0_val(cap0_val), .cap1_val(cap1_val),
  .cap0_irq(cap0_irq), .cap1_irq(cap1_irq), .ovf_irq(ovf_irq)
);

// File: tb/pwc_timer_bench.sv
module pwc_timer_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_en = 1'b0, src_ext = 1'b0;
  logic [1:0]    presc_sel = 2'd0, edge_sel0 = 2'd0, edge_sel1 = 2'd0;
  logic          cap_in0 = 1'b0, cap_in1 = 1'b0;
  logic [CW-1:0] cap0_val, cap1_val;
  logic          cap0_irq, cap1_irq, ovf_irq;

  always #5 clk = ~clk;

  pwc_timer u_pwc_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_ext(src_ext),
    .presc_sel(presc_sel), .edge_sel0(edge_sel0), .edge_sel1(edge_sel1),
    .cap_in0(cap_in0), .cap_in1(cap_in1),
    .cap0_val(cap0_val), .cap1_val(cap1_val),
    .cap0_irq(cap0_irq), .cap1_irq(cap1_irq), .ovf_irq(ovf_irq)
  );

  typedef struct {
    int    ch;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0, n_errors = 0;
  int   irq_seen = 0, ovf_seen = 0;
  bit   done = 0;
  bit   ext_clk_on = 0;
  logic ovf_prev = 1'b0;

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per capture pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (ovf_irq) ovf_seen++;
      if (ovf_irq && ovf_prev) check("R6 ovf width", 2, 1);
      ovf_prev = ovf_irq;
      for (int c = 0; c < 2; c++) begin
        if ((c == 0) ? cap0_irq : cap1_irq) begin
          irq_seen++;
          if (q.size() == 0) begin
            check("R3 unexpected capture channel", c, -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            if (e.ch != c) check({e.tag, " channel"}, c, e.ch);
            else if (e.val >= 0) check(e.tag, int'((c == 0) ? cap0_val : cap1_val), e.val);
          end
        end
      end
    end
  end

  // External event clock on input 0: rising edge every 4 cycles
  always @(negedge clk) begin
    if (ext_clk_on) begin
      int ph;
      ph = ($time / 10) % 4;
      cap_in0 <= (ph < 2);
    end
  end

  task automatic push(int ch, int val, string tag);
    exp_t e;
    e.ch = ch; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(int ch, logic v);
    if (ch == 0) cap_in0 = v;
    else         cap_in1 = v;
  endtask

  // Driver: n valid edges d cycles apart; first one only re-aligns the counter
  task automatic train(int ch, int mode, int d, int n, int val, string tag);
    for (int i = 0; i < n; i++) begin
      int ev;
      ev = (i == 0) ? -1 : val;
      if (mode == 3) begin
        push(ch, ev, tag);
        drive(ch, (i % 2) == 0);
        repeat (d) @(negedge clk);
      end else begin
        if (mode == 1) push(ch, ev, tag);
        drive(ch, 1'b1);
        repeat (d / 2) @(negedge clk);
        if (mode == 2) push(ch, ev, tag);
        drive(ch, 1'b0);
        repeat (d - d / 2) @(negedge clk);
      end
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] held;
    int snap;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cap0 reset", int'(cap0_val), 0);
    check("R1 cap1 reset", int'(cap1_val), 0);
    check("R1 irq reset", int'({cap0_irq, cap1_irq, ovf_irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'({cap0_irq, cap1_irq, ovf_irq}), 0);

    // R2 prescale 1, rising edges on input 1
    edge_sel1 = 2'b01; run_en = 1'b1;
    train(1, 1, 30, 4, 29, "R2 interval d=30");
    train(1, 1, 7, 4, 6, "R2 interval d=7");

    // R3 falling and both-edge decode
    edge_sel1 = 2'b10;
    train(1, 2, 24, 4, 23, "R3 falling d=24");
    edge_sel1 = 2'b11;
    train(1, 3, 16, 4, 15, "R3 both d=16");

    // R3 input set to none is ignored
    edge_sel1 = 2'b01; edge_sel0 = 2'b00;
    snap = irq_seen; held = cap0_val;
    for (int i = 0; i < 6; i++) begin
      cap_in0 = ~cap_in0;
      repeat (9) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check("R3 none gives no pulse", irq_seen, snap);
    check("R3 none keeps cap0", int'(cap0_val), int'(held));

    // R2 on channel 0
    edge_sel1 = 2'b00; edge_sel0 = 2'b01;
    train(0, 1, 20, 4, 19, "R2 channel0 d=20");

    // R4 prescale codes
    edge_sel0 = 2'b00; edge_sel1 = 2'b01;
    presc_sel = 2'd1;
    train(1, 1, 10, 4, 4, "R4 prescale2");
    presc_sel = 2'd2;
    train(1, 1, 40, 4, 9, "R4 prescale4");
    presc_sel = 2'd3;
    train(1, 1, 64, 4, 7, "R4 prescale8");
    presc_sel = 2'd0;

    // R5 external event clock, input 0 select left at rising
    edge_sel0 = 2'b01; src_ext = 1'b1;
    ext_clk_on = 1;
    repeat (8) @(negedge clk);
    train(1, 1, 40, 4, 9, "R5 external clock d=40");
    ext_clk_on = 0;
    @(negedge clk);
    cap_in0 = 1'b0;
    repeat (8) @(negedge clk);
    src_ext = 1'b0; edge_sel0 = 2'b00;
    repeat (8) @(negedge clk);

    // R6 long interval: one wrap, low 16 bits captured
    push(1, -1, "R6 prime");
    cap_in1 = 1'b1; repeat (5) @(negedge clk); cap_in1 = 1'b0;
    snap = ovf_seen;
    repeat (65546 - 5) @(negedge clk);
    push(1, 9, "R6 wrapped capture");
    cap_in1 = 1'b1; repeat (5) @(negedge clk); cap_in1 = 1'b0;
    repeat (10) @(negedge clk);
    check("R6 single overflow", ovf_seen - snap, 1);

    // R7 disabled: nothing captured, values held
    run_en = 1'b0;
    held = cap1_val; snap = irq_seen;
    for (int i = 0; i < 6; i++) begin
      cap_in1 = ~cap_in1;
      repeat (6) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check("R7 no capture when off", irq_seen, snap);
    check("R7 cap1 held", int'(cap1_val), int'(held));
    check("R7 cap1 held value", int'(cap1_val), 9);

    // R8 count restarts from zero at enable
    run_en = 1'b1;
    repeat (20) @(negedge clk);
    push(1, 22, "R8 first interval after enable");
    cap_in1 = 1'b1;
    repeat (10) @(negedge clk);
    cap_in1 = 1'b0;
    repeat (10) @(negedge clk);

    // R9 every pulse matched
    check("R9 queue drained", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule